// File: doc/BRIEF.md
# Loss Threshold Beam Permit Guard

This block decides, cycle by cycle, whether a protection card may keep granting beam permit. Integrated loss readings arrive one per clock, each tagged with its detector channel and integration window. Each reading is checked against a threshold held in an internal table. The table is addressed by channel, window and the beam energy level most recently announced. A reading strictly above its threshold, on a channel that is not masked, latches a dump request and records which channel and window caused it.

Permit leaves the block as a square wave rather than a level. While permit is granted the wave runs at one half-period. While permit is denied, whether by a dump, a reset or a stale supervision input, it runs at a different half-period. A receiver that sees the wrong rate, or no edges at all, treats the line as no permit. Two freshness timers also gate permit. One covers the beam energy update. The other covers the last passed acquisition-chain check, nominally 24 hours at a 40 MHz clock.

The controller has three states. `ST_WAIT` means no permit and nothing latched. `ST_GIVE` means permit is granted. `ST_TRIP` means a dump is latched. Its transitions are:
- WAIT→GIVE when both timers are fresh.
- GIVE→WAIT when either timer goes stale.
- WAIT→TRIP and GIVE→TRIP on an exceedance.
- TRIP→WAIT on a clear with no exceedance in the same cycle.
- TRIP→TRIP, with the cause overwritten, on a clear that meets an exceedance.

Top module: `loss_permit_guard`

## Requirements
- R1: After reset, `dump_req` is 0, `permit_clk` is 0 and the controller is in the no-permit state.
- R2: The permit wave uses half-period GIVE_HALF only while an energy strobe has arrived within the last ENERGY_TIMEOUT cycles and a check pass has arrived within the last CHECK_TIMEOUT cycles.
- R3: A reading strictly greater than the threshold at {channel, window, current energy level} raises `dump_req` at the second rising edge after the reading is presented. A reading equal to its threshold does not.
- R4: The threshold is chosen by the energy level latched at the last `energy_stb`. The same reading can trip at one level and pass at another.
- R5: A reading on a channel whose `chan_mask` bit is 1 never causes a dump.
- R6: `dump_req` stays high until `trip_clear`. `trip_ch` and `trip_win` hold the cause of the first exceedance, and later exceedances do not change them. A clear returns the controller to the no-permit state.
- R7: If `trip_clear` meets an exceedance in the same cycle, `dump_req` stays high and the cause fields take the new exceedance.
- R8: A stale energy update withdraws permit (wave at DENY_HALF) without raising `dump_req`.
- R9: A stale acquisition-chain check withdraws permit (wave at DENY_HALF).
- R10: While no permit is granted, including while a dump is latched, the wave toggles every DENY_HALF cycles.
- R11: A reading whose window index is NUM_WIN or greater is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| energy_lvl | input | LVL_W | Beam energy level, taken when energy_stb is high |
| energy_stb | input | 1 | Energy update strobe |
| check_pass | input | 1 | Pulse: acquisition-chain check passed |
| chan_mask | input | NUM_CH | 1 excludes the channel from tripping |
| smp_valid | input | 1 | Loss reading present |
| smp_ch | input | CH_W | Channel of the reading |
| smp_win | input | WIN_W | Integration window of the reading |
| smp_val | input | DATA_W | Integrated loss value |
| tbl_we | input | 1 | Threshold table write enable |
| tbl_ch | input | CH_W | Write address: channel |
| tbl_win | input | WIN_W | Write address: window |
| tbl_lvl | input | LVL_W | Write address: energy level |
| tbl_data | input | DATA_W | Threshold value to write |
| trip_clear | input | 1 | Clears a latched dump |
| permit_clk | output | 1 | Permit square wave |
| dump_req | output | 1 | Latched dump request |
| trip_ch | output | CH_W | Channel that caused the dump |
| trip_win | output | WIN_W | Window that caused the dump |

## Verification
The operator clear and the exceedance detector can act in the same cycle. The bench sets this up by presenting an exceeding reading on a second channel one cycle before it asserts `trip_clear`, so that the comparison result and the clear reach the controller at the same edge. The outcome is judged from the ports. `dump_req` must not drop, and `trip_ch`/`trip_win` must move to the second channel. A following clear on its own must then release the dump.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_GIVE = 2'd1,
        ST_TRIP = 2'd2
    } guard_state_t;
endpackage

// File: rtl/thr_table.sv
module thr_table #(
    parameter int DEPTH  = 6144,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/freshness_timer.sv
module freshness_timer #(
    parameter longint unsigned LIMIT = 64'd40,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic fresh
);
    logic [CW-1:0] age;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age  <= '0;
            seen <= 1'b0;
        end else if (pulse) begin
            age  <= '0;
            seen <= 1'b1;
        end else if (age != LIMIT[CW-1:0]) begin
            age <= age + CW'(1);
        end
    end

    assign fresh = seen && (age < LIMIT[CW-1:0]);
endmodule

// File: rtl/permit_tone.sv
module permit_tone #(
    parameter int GIVE_HALF = 4,
    parameter int DENY_HALF = 16,
    localparam int MAXH = (GIVE_HALF > DENY_HALF) ? GIVE_HALF : DENY_HALF,
    localparam int CW   = $clog2(MAXH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic give,
    output logic tone
);
    logic [CW-1:0] cnt;
    logic          mode_q;
    logic [CW-1:0] lim;

    assign lim = give ? CW'(GIVE_HALF - 1) : CW'(DENY_HALF - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            mode_q <= 1'b0;
            tone   <= 1'b0;
        end else begin
            mode_q <= give;
            if (give != mode_q) begin
                cnt <= '0;
            end else if (cnt == lim) begin
                cnt  <= '0;
                tone <= ~tone;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/loss_permit_guard.sv
module loss_permit_guard
    import lpg_pkg::*;
#(
    parameter int              NUM_CH         = 16,
    parameter int              NUM_WIN        = 12,
    parameter int              LVL_W          = 5,
    parameter int              DATA_W         = 16,
    parameter int              GIVE_HALF      = 4,
    parameter int              DENY_HALF      = 16,
    parameter longint unsigned ENERGY_TIMEOUT = 64'd4000,
    parameter longint unsigned CHECK_TIMEOUT  = 64'd3456000000000,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int WIN_W   = $clog2(NUM_WIN),
    localparam int NUM_LVL = 1 << LVL_W,
    localparam int DEPTH   = NUM_CH * NUM_WIN * NUM_LVL,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  energy_lvl,
    input  logic              energy_stb,
    input  logic              check_pass,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_ch,
    input  logic [WIN_W-1:0]  smp_win,
    input  logic [DATA_W-1:0] smp_val,
    input  logic              tbl_we,
    input  logic [CH_W-1:0]   tbl_ch,
    input  logic [WIN_W-1:0]  tbl_win,
    input  logic [LVL_W-1:0]  tbl_lvl,
    input  logic [DATA_W-1:0] tbl_data,
    input  logic              trip_clear,
    output logic              permit_clk,
    output logic              dump_req,
    output logic [CH_W-1:0]   trip_ch,
    output logic [WIN_W-1:0]  trip_win
);
    guard_state_t      state, state_nx;
    logic [LVL_W-1:0]  cur_lvl;
    logic              e_fresh, c_fresh, all_fresh;
    logic              s_valid;
    logic [DATA_W-1:0] s_val;
    logic [CH_W-1:0]   s_ch;
    logic [WIN_W-1:0]  s_win;
    logic [DATA_W-1:0] thr_q;
    logic              hit;
    logic              give;
    logic              capture;
    logic [AW-1:0]     rd_addr, wr_addr;
    logic              smp_ok;

    // energy level latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= '0;
        end else if (energy_stb) begin
            cur_lvl <= energy_lvl;
        end
    end

    // table addressing: {channel, window, level} flattened
    assign rd_addr = AW'((int'(smp_ch) * NUM_WIN + int'(smp_win)) * NUM_LVL + int'(cur_lvl));
    assign wr_addr = AW'((int'(tbl_ch) * NUM_WIN + int'(tbl_win)) * NUM_LVL + int'(tbl_lvl));

    thr_table #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_table (
        .clk   (clk),
        .we    (tbl_we && (int'(tbl_win) < NUM_WIN) && (int'(tbl_ch) < NUM_CH)),
        .waddr (wr_addr),
        .wdata (tbl_data),
        .raddr (rd_addr),
        .rdata (thr_q)
    );

    // reading stage, aligned with the table read
    assign smp_ok = smp_valid && !chan_mask[smp_ch]
                    && (int'(smp_win) < NUM_WIN) && (int'(smp_ch) < NUM_CH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_val   <= '0;
            s_ch    <= '0;
            s_win   <= '0;
        end else begin
            s_valid <= smp_ok;
            s_val   <= smp_val;
            s_ch    <= smp_ch;
            s_win   <= smp_win;
        end
    end

    assign hit = s_valid && (s_val > thr_q);

    // supervision timers
    freshness_timer #(.LIMIT(ENERGY_TIMEOUT)) u_energy_age (
        .clk(clk), .rst_n(rst_n), .pulse(energy_stb), .fresh(e_fresh)
    );
    freshness_timer #(.LIMIT(CHECK_TIMEOUT)) u_check_age (
        .clk(clk), .rst_n(rst_n), .pulse(check_pass), .fresh(c_fresh)
    );
    assign all_fresh = e_fresh && c_fresh;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: begin
                if (hit)            state_nx = ST_TRIP;
                else if (all_fresh) state_nx = ST_GIVE;
            end
            ST_GIVE: begin
                if (hit)             state_nx = ST_TRIP;
                else if (!all_fresh) state_nx = ST_WAIT;
            end
            ST_TRIP: begin
                if (trip_clear && !hit) state_nx = ST_WAIT;
            end
            default: state_nx = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        dump_req = (state == ST_TRIP);
        give     = (state == ST_GIVE);
        capture  = hit && ((state != ST_TRIP) || trip_clear);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_ch  <= '0;
            trip_win <= '0;
        end else if (capture) begin
            trip_ch  <= s_ch;
            trip_win <= s_win;
        end
    end

    permit_tone #(.GIVE_HALF(GIVE_HALF), .DENY_HALF(DENY_HALF)) u_tone (
        .clk(clk), .rst_n(rst_n), .give(give), .tone(permit_clk)
    );
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker
    import lpg_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int WIN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_clear,
    input logic             dump_req,
    input logic [CH_W-1:0]  trip_ch,
    input logic [WIN_W-1:0] trip_win,
    input logic             hit,
    input guard_state_t     permit_state,
    input logic             e_fresh,
    input logic             c_fresh
);
    AST_DUMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        dump_req && !trip_clear |=> dump_req); // R6

    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dump_req && !trip_clear |=> $stable(trip_ch) && $stable(trip_win)); // R6

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        dump_req && trip_clear && !hit |=> !dump_req); // R6

    AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        trip_clear && hit |=> dump_req); // R7

    AST_DUMP_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dump_req) |-> $past(hit)); // R3

    AST_GIVE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (permit_state == ST_GIVE) |-> $past(e_fresh && c_fresh)); // R2
endmodule

bind loss_permit_guard lpg_checker #(.CH_W(CH_W), .WIN_W(WIN_W)) u_lpg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_clear   (trip_clear),
    .dump_req     (dump_req),
    .trip_ch      (trip_ch),
    .trip_win     (trip_win),
    .hit          (hit),
    .permit_state (state),
    .e_fresh      (e_fresh),
    .c_fresh      (c_fresh)
);

// File: tb/loss_permit_guard_test.sv
module loss_permit_guard_test;
    localparam int NUM_CH = 16, NUM_WIN = 12, LVL_W = 5, DATA_W = 16;
    localparam int CH_W = 4, WIN_W = 4;
    localparam int GH = 3, DH = 7;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic [LVL_W-1:0]  energy_lvl;
    logic              energy_stb, check_pass;
    logic [NUM_CH-1:0] chan_mask = '0;
    logic              smp_valid = 1'b0;
    logic [CH_W-1:0]   smp_ch = '0;
    logic [WIN_W-1:0]  smp_win = '0;
    logic [DATA_W-1:0] smp_val = '0;
    logic              tbl_we = 1'b0;
    logic [CH_W-1:0]   tbl_ch = '0;
    logic [WIN_W-1:0]  tbl_win = '0;
    logic [LVL_W-1:0]  tbl_lvl = '0;
    logic [DATA_W-1:0] tbl_data = '0;
    logic              trip_clear = 1'b0;
    logic              permit_clk, dump_req;
    logic [CH_W-1:0]   trip_ch;
    logic [WIN_W-1:0]  trip_win;

    int n_chk = 0, n_bad = 0;
    bit keep_e = 0, keep_c = 0;
    logic [LVL_W-1:0] lvl_req = 5'd2;

    loss_permit_guard #(
        .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .LVL_W(LVL_W), .DATA_W(DATA_W),
        .GIVE_HALF(GH), .DENY_HALF(DH),
        .ENERGY_TIMEOUT(64'd40), .CHECK_TIMEOUT(64'd300)
    ) uut (.*);

    always #5 clk = ~clk;

    initial begin
        energy_stb = 1'b0;
        energy_lvl = '0;
        forever begin
            repeat (9) @(negedge clk);
            energy_stb = keep_e;
            energy_lvl = lvl_req;
            @(negedge clk);
            energy_stb = 1'b0;
        end
    end

    initial begin
        check_pass = 1'b0;
        forever begin
            repeat (99) @(negedge clk);
            check_pass = keep_c;
            @(negedge clk);
            check_pass = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure_half(output int h);
        logic p;
        int   c;
        p = permit_clk;
        c = 0;
        while (permit_clk == p && c < 100) begin @(negedge clk); c++; end
        p = permit_clk;
        c = 0;
        while (permit_clk == p && c < 100) begin @(negedge clk); c++; end
        h = c;
    endtask

    task automatic wr_thr(input int ch, input int win, input int lvl, input int val);
        @(negedge clk);
        tbl_ch = CH_W'(ch); tbl_win = WIN_W'(win); tbl_lvl = LVL_W'(lvl);
        tbl_data = DATA_W'(val); tbl_we = 1'b1;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // present one reading, then wait until its result is visible
    task automatic send(input int ch, input int win, input int val);
        @(negedge clk);
        smp_ch = CH_W'(ch); smp_win = WIN_W'(win); smp_val = DATA_W'(val); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        trip_clear = 1'b1;
        @(negedge clk);
        trip_clear = 1'b0;
    endtask

    task automatic t_reset();
        int h;
        check("R1 dump_req after reset", dump_req, 0);
        check("R1 permit_clk after reset", permit_clk, 0);
        measure_half(h);
        check("R10 deny half-period with no supervision", h, DH);
    endtask

    task automatic t_permit();
        int h;
        keep_e = 1; keep_c = 1;
        repeat (130) @(negedge clk);
        measure_half(h);
        check("R2 give half-period", h, GH);
    endtask

    task automatic t_threshold();
        int h;
        send(3, 5, 1000);
        check("R3 equal value no dump", dump_req, 0);
        send(3, 5, 1001);
        check("R3 above threshold dumps", dump_req, 1);
        check("R6 cause channel", trip_ch, 3);
        check("R6 cause window", trip_win, 5);
        measure_half(h);
        check("R10 deny half-period while tripped", h, DH);
        send(9, 0, 11);
        check("R6 latched dump kept", dump_req, 1);
        check("R6 cause channel unchanged", trip_ch, 3);
        do_clear();
        check("R6 clear releases dump", dump_req, 0);
        repeat (5) @(negedge clk);
        measure_half(h);
        check("R6 permit resumes after clear", h, GH);
    endtask

    task automatic t_energy_sel();
        lvl_req = 5'd7;
        repeat (25) @(negedge clk);
        send(3, 5, 3000);
        check("R4 level 7 threshold not exceeded", dump_req, 0);
        lvl_req = 5'd2;
        repeat (25) @(negedge clk);
        send(3, 5, 3000);
        check("R4 level 2 threshold exceeded", dump_req, 1);
        do_clear();
    endtask

    task automatic t_mask();
        chan_mask[3] = 1'b1;
        send(3, 5, 60000);
        check("R5 masked channel ignored", dump_req, 0);
        chan_mask[3] = 1'b0;
        send(3, 5, 60000);
        check("R5 unmasked channel trips", dump_req, 1);
        do_clear();
    endtask

    task automatic t_window();
        send(3, 13, 60000);
        check("R11 window beyond range ignored", dump_req, 0);
    endtask

    task automatic t_same_cycle();
        send(3, 5, 1001);
        check("R7 initial trip", trip_ch, 3);
        @(negedge clk);
        smp_ch = 4'd9; smp_win = 4'd0; smp_val = 16'd11; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; trip_clear = 1'b1;
        @(negedge clk);
        trip_clear = 1'b0;
        check("R7 dump stays when clear meets exceedance", dump_req, 1);
        check("R7 cause channel replaced", trip_ch, 9);
        check("R7 cause window replaced", trip_win, 0);
        do_clear();
        check("R7 plain clear releases", dump_req, 0);
    endtask

    task automatic t_energy_stale();
        int h;
        keep_e = 0;
        repeat (60) @(negedge clk);
        measure_half(h);
        check("R8 stale energy denies permit", h, DH);
        check("R8 no dump on stale energy", dump_req, 0);
        keep_e = 1;
        repeat (25) @(negedge clk);
        measure_half(h);
        check("R8 permit back with energy", h, GH);
    endtask

    task automatic t_check_stale();
        int h;
        keep_c = 0;
        repeat (350) @(negedge clk);
        measure_half(h);
        check("R9 stale check denies permit", h, DH);
        keep_c = 1;
        repeat (130) @(negedge clk);
        measure_half(h);
        check("R9 permit back after check", h, GH);
    endtask

    initial begin
        #(10 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr_thr(3, 5, 2, 1000);
        wr_thr(3, 5, 7, 5000);
        wr_thr(9, 0, 2, 10);
        t_permit();
        t_threshold();
        t_energy_sel();
        t_mask();
        t_window();
        t_same_cycle();
        t_energy_stale();
        t_check_stale();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule